// File: doc/BRIEF.md
# Asynchronous Pseudo-Static RAM Bus Controller

This block bridges a synchronous host port to an external 512K x 16 pseudo-static RAM with an asynchronous interface. The host raises a request with a word address, write data, two byte-lane enables and a read/write flag, and holds them until the block answers with a one-clock acknowledge. For a read, the captured word arrives with that acknowledge. On the memory side the block drives two chip selects, output enable, write enable, two byte-lane strobes, an address bus and a split data bus. The split data bus has a drive-enable for the tri-state pads.

Every memory timing interval is given in nanoseconds together with the clock period. Each interval is turned into a cycle count at elaboration: the count is the interval divided by the clock period, rounded up, and never less than one. All memory-side outputs are registered, so they change only at a clock edge and never glitch.

Pseudo-static parts refresh themselves and need a regular deselect gap to do so. A refresh guard therefore watches chip-enable-1. Once the chip has stayed selected for too long without a deselect gap of at least one read-cycle time, the guard stalls new requests. The current access is allowed to finish, and then the guard inserts such a gap.

The control machine has six states:
- `ST_IDLE`: waiting for a request; the chip is deselected.
- `ST_READ`: read access with output enable low.
- `ST_TURN`: bus turnaround after a read; the chip is deselected.
- `ST_WRITE`: write-enable pulse.
- `ST_WHOLD`: write end; write enable high, chip still selected, data still driven.
- `ST_GAP`: refresh gap; chip-enable-1 high.

The transitions are:
- `ST_IDLE` to `ST_GAP` when a refresh is due. This takes priority over a request.
- `ST_IDLE` to `ST_READ` or to `ST_WRITE` on a request, chosen by the read/write flag.
- `ST_READ` to `ST_TURN`, `ST_TURN` to `ST_IDLE`, `ST_WRITE` to `ST_WHOLD`, `ST_WHOLD` to `ST_IDLE` and `ST_GAP` to `ST_IDLE`, each when that state's timer expires.

Top module: `psram_async_ctrl`

## Requirements
- R1: While reset is held and after its release until a request is accepted, mem_ce1_n=1, mem_ce2=0, mem_oe_n=1, mem_we_n=1, mem_ub_n=1, mem_lb_n=1, mem_dq_oe=0 and host_ack=0.
- R2: A read drives mem_ce1_n=0, mem_ce2=1, mem_we_n=1 and mem_oe_n=0 for ACC cycles, where ACC is the larger of the access time and the read-cycle time in cycles. The word on mem_dq_i is captured on the edge that ends that interval, and host_ack is high for the following cycle with the word on host_rdata. With a 10 ns clock and 55 ns timings, the acknowledge is seen 7 clock periods after an idle block is handed the request.
- R3: A write keeps mem_we_n low for ceil(T_WP_NS/CLK_NS) cycles with the chip selected and mem_dq_oe=1. It then keeps mem_we_n high for the rest of the write-cycle time, with the chip still selected and the same address and data driven, before host_ack pulses. The address does not change while mem_we_n is low.
- R4: host_be bit 0 enables the byte on bits 7:0 (mem_lb_n low) and host_be bit 1 enables the byte on bits 15:8 (mem_ub_n low). A write leaves the bytes of disabled lanes unchanged in memory, and a read returns only the enabled lanes.
- R5: mem_dq_oe is high only while mem_oe_n is high. After mem_oe_n rises, mem_dq_oe stays low for at least ceil(T_HZ_NS/CLK_NS) cycles.
- R6: chip-enable-1 is never low for T_WIN_NS/CLK_NS cycles without a completed gap of at least one read-cycle time with mem_ce1_n high. Under an unbroken stream of requests the block inserts such a gap by itself.
- R7: Every interval is converted to cycles by rounding up to whole clock periods, with a minimum of one cycle. With the defaults (10 ns clock; 55 ns access and cycle time, 45 ns write pulse, 25 ns turnaround) this gives 6 read cycles, 5 write-pulse cycles and 3 turnaround cycles.
- R8: A request is accepted only in ST_IDLE, and each accepted request yields exactly one acknowledge, which is one clock wide. Requests complete in the order they are issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Request; held with its fields until host_ack |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 19 | Word address |
| host_wdata | input | 16 | Write data |
| host_be | input | 2 | Byte-lane enables (bit 0 low byte, bit 1 high byte) |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Read word, valid with host_ack |
| mem_addr | output | 19 | Memory address |
| mem_ce1_n | output | 1 | Chip enable 1, active low |
| mem_ce2 | output | 1 | Chip enable 2, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_dq_o | output | 16 | Data driven to the pads |
| mem_dq_oe | output | 1 | Pad drive enable |
| mem_dq_i | input | 16 | Data from the pads |

## Verification
The bench drives several kinds of traffic, and each one exposes a different fault:
- Isolated accesses from an idle block pin down latency and pin levels in the middle of a cycle, so an off-by-one timer or a wrong strobe shows.
- Three single-lane and dual-lane writes to one address, read back whole and one lane at a time, separate lane mapping from lane masking.
- Accesses at addresses 0 and 0x7FFFF catch address truncation.
- An interleaved write/read stream with changing data exposes ordering faults and read/write turnaround faults.
- A long unbroken stream of reads exercises the refresh guard: without it, the normal inter-access gap is shorter than one read-cycle time and the selection window is exceeded.

// File: rtl/psram_ctrl_pkg.sv
package psram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_TURN,
        ST_WRITE,
        ST_WHOLD,
        ST_GAP
    } ctrl_state_e;

    // ceil(ns / clk_ns), never below one cycle
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psram_step_timer.sv
module psram_step_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/psram_refresh_guard.sv
module psram_refresh_guard #(
    parameter int unsigned RC_CYC    = 6,
    parameter int unsigned LIMIT_CYC = 1482
) (
    input  logic clk,
    input  logic rst,
    input  logic ce1_n,
    output logic due
);
    localparam int unsigned GW = $clog2(RC_CYC + 1);
    localparam int unsigned WW = $clog2(LIMIT_CYC + 1);
    localparam logic [GW-1:0] GAP_DONE  = GW'(RC_CYC - 1);
    localparam logic [GW-1:0] GAP_SAT   = GW'(RC_CYC);
    localparam logic [WW-1:0] WIN_LIMIT = WW'(LIMIT_CYC);

    logic [GW-1:0] gap_q;
    logic [WW-1:0] win_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= '0;
            win_q <= '0;
        end else begin
            if (!ce1_n)               gap_q <= '0;
            else if (gap_q < GAP_SAT) gap_q <= gap_q + 1'b1;

            if (ce1_n && gap_q >= GAP_DONE) win_q <= '0;
            else if (win_q < WIN_LIMIT)      win_q <= win_q + 1'b1;
        end
    end

    assign due = (win_q >= WIN_LIMIT);
endmodule

// File: rtl/psram_async_ctrl.sv
module psram_async_ctrl
    import psram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W   = 19,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned CLK_NS   = 10,
    parameter int unsigned T_RC_NS  = 55,
    parameter int unsigned T_ACC_NS = 55,
    parameter int unsigned T_WC_NS  = 55,
    parameter int unsigned T_WP_NS  = 45,
    parameter int unsigned T_HZ_NS  = 25,
    parameter int unsigned T_WIN_NS = 15000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [1:0]        host_be,
    output logic              host_ack,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce1_n,
    output logic              mem_ce2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int unsigned RC_CYC  = ns_to_cyc(T_RC_NS, CLK_NS);
    localparam int unsigned ACC_CYC = max_u(ns_to_cyc(T_ACC_NS, CLK_NS), RC_CYC);
    localparam int unsigned WP_CYC  = ns_to_cyc(T_WP_NS, CLK_NS);
    localparam int unsigned WC_CYC  = ns_to_cyc(T_WC_NS, CLK_NS);
    localparam int unsigned WH_CYC  = (WC_CYC > WP_CYC) ? (WC_CYC - WP_CYC) : 1;
    localparam int unsigned HZ_CYC  = ns_to_cyc(T_HZ_NS, CLK_NS);
    localparam int unsigned WIN_CYC = T_WIN_NS / CLK_NS;
    localparam int unsigned MAX_TXN = max_u(1 + ACC_CYC + HZ_CYC, 1 + WP_CYC + WH_CYC);
    localparam int unsigned LIMIT_CYC = WIN_CYC - MAX_TXN - RC_CYC - 2;
    localparam int unsigned MAX_DUR = max_u(max_u(ACC_CYC, WP_CYC), max_u(max_u(WH_CYC, HZ_CYC), RC_CYC));
    localparam int unsigned TW      = $clog2(MAX_DUR + 1);

    ctrl_state_e   state_q, state_d;
    logic          tmr_zero, tmr_load, refresh_due, accept;
    logic [TW-1:0] dur_d;
    logic [1:0]    be_q, lanes_d;
    logic          sel_d;

    psram_step_timer #(.CNT_W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (dur_d),
        .zero     (tmr_zero)
    );

    psram_refresh_guard #(.RC_CYC(RC_CYC), .LIMIT_CYC(LIMIT_CYC)) u_guard (
        .clk   (clk),
        .rst   (rst),
        .ce1_n (mem_ce1_n),
        .due   (refresh_due)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // next state and per-state duration
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (refresh_due)   state_d = ST_GAP;
                else if (host_req) state_d = host_wr ? ST_WRITE : ST_READ;
            end
            ST_READ:  if (tmr_zero) state_d = ST_TURN;
            ST_TURN:  if (tmr_zero) state_d = ST_IDLE;
            ST_WRITE: if (tmr_zero) state_d = ST_WHOLD;
            ST_WHOLD: if (tmr_zero) state_d = ST_IDLE;
            ST_GAP:   if (tmr_zero) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase

        unique case (state_d)
            ST_READ:  dur_d = TW'(ACC_CYC - 1);
            ST_TURN:  dur_d = TW'(HZ_CYC - 1);
            ST_WRITE: dur_d = TW'(WP_CYC - 1);
            ST_WHOLD: dur_d = TW'(WH_CYC - 1);
            ST_GAP:   dur_d = TW'(RC_CYC - 1);
            default:  dur_d = '0;
        endcase
    end

    assign tmr_load = (state_d != state_q);
    assign accept   = (state_q == ST_IDLE) && (state_d == ST_READ || state_d == ST_WRITE);
    assign sel_d    = (state_d == ST_READ) || (state_d == ST_WRITE) || (state_d == ST_WHOLD);
    assign lanes_d  = accept ? host_be : be_q;

    // registered outputs, decoded from the next state
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_ce1_n  <= 1'b1;
            mem_ce2    <= 1'b0;
            mem_oe_n   <= 1'b1;
            mem_we_n   <= 1'b1;
            mem_ub_n   <= 1'b1;
            mem_lb_n   <= 1'b1;
            mem_dq_oe  <= 1'b0;
            mem_addr   <= '0;
            mem_dq_o   <= '0;
            be_q       <= '0;
            host_ack   <= 1'b0;
            host_rdata <= '0;
        end else begin
            if (accept) begin
                mem_addr <= host_addr;
                mem_dq_o <= host_wdata;
                be_q     <= host_be;
            end
            mem_ce1_n <= !sel_d;
            mem_ce2   <= sel_d;
            mem_oe_n  <= !(state_d == ST_READ);
            mem_we_n  <= !(state_d == ST_WRITE);
            mem_lb_n  <= !(sel_d && lanes_d[0]);
            mem_ub_n  <= !(sel_d && lanes_d[1]);
            mem_dq_oe <= (state_d == ST_WRITE) || (state_d == ST_WHOLD);
            host_ack  <= tmr_zero && (state_q == ST_READ || state_q == ST_WHOLD);
            if (state_q == ST_READ && tmr_zero) host_rdata <= mem_dq_i;
        end
    end
endmodule

// File: rtl/psram_ctrl_checker.sv
module psram_ctrl_checker
    import psram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W   = 19,
    parameter int unsigned CLK_NS   = 10,
    parameter int unsigned T_RC_NS  = 55,
    parameter int unsigned T_WP_NS  = 45,
    parameter int unsigned T_HZ_NS  = 25,
    parameter int unsigned T_WIN_NS = 15000
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_ce1_n,
    input logic              mem_ce2,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_dq_oe,
    input logic              host_ack
);
    localparam int unsigned RC_C  = ns_to_cyc(T_RC_NS, CLK_NS);
    localparam int unsigned WP_C  = ns_to_cyc(T_WP_NS, CLK_NS);
    localparam int unsigned HZ_C  = ns_to_cyc(T_HZ_NS, CLK_NS);
    localparam int unsigned WIN_C = T_WIN_NS / CLK_NS;

    int unsigned oe_hi_cnt, we_lo_cnt, gap_cnt, run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_hi_cnt <= HZ_C;
            we_lo_cnt <= 0;
            gap_cnt   <= 0;
            run_cnt   <= 0;
        end else begin
            oe_hi_cnt <= !mem_oe_n ? 0 : ((oe_hi_cnt < HZ_C) ? oe_hi_cnt + 1 : oe_hi_cnt);
            we_lo_cnt <= mem_we_n ? 0 : ((we_lo_cnt < WP_C) ? we_lo_cnt + 1 : we_lo_cnt);
            gap_cnt   <= !mem_ce1_n ? 0 : ((gap_cnt < RC_C) ? gap_cnt + 1 : gap_cnt);
            run_cnt   <= (mem_ce1_n && gap_cnt + 1 >= RC_C) ? 0
                       : ((run_cnt < WIN_C) ? run_cnt + 1 : run_cnt);
        end
    end

    p_read_ctl_r2: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (!mem_ce1_n && mem_ce2 && mem_we_n));

    p_we_width_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (we_lo_cnt >= WP_C));

    p_addr_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n && !$past(mem_we_n)) |-> $stable(mem_addr));

    p_bus_free_r5: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n);

    p_turn_gap_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe) |-> (oe_hi_cnt >= HZ_C));

    p_refresh_window_r6: assert property (@(posedge clk) disable iff (rst)
        run_cnt < WIN_C);

    p_ack_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        host_ack |=> !host_ack);
endmodule

bind psram_async_ctrl psram_ctrl_checker #(
    .ADDR_W   (ADDR_W),
    .CLK_NS   (CLK_NS),
    .T_RC_NS  (T_RC_NS),
    .T_WP_NS  (T_WP_NS),
    .T_HZ_NS  (T_HZ_NS),
    .T_WIN_NS (T_WIN_NS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_ce1_n (mem_ce1_n),
    .mem_ce2   (mem_ce2),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_addr  (mem_addr),
    .mem_dq_oe (mem_dq_oe),
    .host_ack  (host_ack)
);

// File: tb/psram_async_ctrl_tb.sv
module psram_async_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0, host_wr = 1'b0;
    logic [18:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [1:0]  host_be = '0;
    logic        host_ack;
    logic [15:0] host_rdata;
    logic [18:0] mem_addr;
    logic        mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;
    logic [15:0] mem_dq_o, mem_dq_i;

    always #5 clk = ~clk;

    psram_async_ctrl dut_i (
        .clk(clk), .rst(rst), .host_req(host_req), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_be(host_be),
        .host_ack(host_ack), .host_rdata(host_rdata), .mem_addr(mem_addr),
        .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    int n_chk = 0, n_err = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [15:0] mm [int];
    logic        model_on = 1'b0;

    always_comb begin
        mem_dq_i = 16'h0;
        if (!mem_ce1_n && mem_ce2 && !mem_oe_n && mem_we_n && mm.exists(int'(mem_addr))) begin
            if (!mem_lb_n) mem_dq_i[7:0]  = mm[int'(mem_addr)][7:0];
            if (!mem_ub_n) mem_dq_i[15:8] = mm[int'(mem_addr)][15:8];
        end
    end

    always @(posedge mem_we_n) begin
        if (model_on && !mem_ce1_n && mem_ce2) begin
            logic [15:0] w;
            w = mm.exists(int'(mem_addr)) ? mm[int'(mem_addr)] : 16'h0;
            if (!mem_lb_n) w[7:0]  = mem_dq_o[7:0];
            if (!mem_ub_n) w[15:8] = mem_dq_o[15:8];
            mm[int'(mem_addr)] = w;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        bit          rd;
        logic [15:0] data;
        logic [15:0] mask;
    } exp_t;
    exp_t        sq[$];
    logic [15:0] shadow [int];

    always @(negedge clk) begin
        if (!rst && host_ack) begin
            if (sq.size() == 0) begin
                check(1'b0, "R8 ack without request", 1, 0);
            end else begin
                exp_t e;
                e = sq.pop_front();
                if (e.rd)
                    check((host_rdata & e.mask) == e.data, "R2/R4 read data",
                          host_rdata & e.mask, e.data);
            end
        end
    end

    // ---------------- pin monitors ----------------
    int we_lo = 0, oe_hi = 100, gap_run = 0, sel_run = 0, max_run = 0, refresh_gaps = 0;
    logic dq_oe_prev = 1'b0;

    always @(negedge clk) begin
        if (rst) begin
            we_lo = 0; oe_hi = 100; gap_run = 0; sel_run = 0; dq_oe_prev = 1'b0;
        end else begin
            if (!mem_we_n) we_lo++;
            else if (we_lo > 0) begin
                check(we_lo == 5, "R3 write pulse cycles", we_lo, 5);
                we_lo = 0;
            end
            if (mem_dq_oe && !dq_oe_prev) begin
                check(oe_hi >= 3 && mem_oe_n, "R5 turnaround before drive", oe_hi, 3);
            end
            dq_oe_prev = mem_dq_oe;
            if (!mem_oe_n) oe_hi = 0; else oe_hi++;
            if (mem_ce1_n) gap_run++; else gap_run = 0;
            if (gap_run == 6) refresh_gaps++;
            if (gap_run >= 6) sel_run = 0; else sel_run++;
            if (sel_run > max_run) max_run = sel_run;
        end
    end

    // ---------------- driver ----------------
    task automatic do_op(input bit wr, input logic [18:0] a, input logic [15:0] d,
                         input logic [1:0] be, input bit fresh);
        exp_t e;
        int   lat;
        logic [15:0] m;
        m = {{8{be[1]}}, {8{be[0]}}};
        if (fresh) repeat (12) @(negedge clk);
        if (wr) begin
            logic [15:0] s;
            s = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0;
            s = (s & ~m) | (d & m);
            shadow[int'(a)] = s;
            e.rd = 1'b0; e.data = 16'h0; e.mask = 16'h0;
        end else begin
            e.rd = 1'b1;
            e.mask = m;
            e.data = (shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0) & m;
        end
        sq.push_back(e);
        host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d; host_be = be;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            if (fresh && lat == 3) begin
                if (wr) begin
                    check(!mem_ce1_n && mem_ce2 && !mem_we_n && mem_oe_n && mem_dq_oe,
                          "R3 write strobes mid-pulse",
                          {mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b01011);
                    check(mem_dq_o == d && mem_addr == a, "R3 write data/address", mem_dq_o, d);
                end else begin
                    check(!mem_ce1_n && mem_ce2 && mem_we_n && !mem_oe_n && !mem_dq_oe,
                          "R2 read strobes mid-access",
                          {mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b01100);
                end
                check({mem_ub_n, mem_lb_n} == ~be, "R4 lane strobes", {mem_ub_n, mem_lb_n}, ~be);
            end
        end while (!host_ack && lat < 5000);
        host_req = 1'b0;
        if (fresh) check(lat == 7, "R7 latency from idle", lat, 7);
    endtask

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    // ---------------- sequence ----------------
    initial begin
        repeat (4) @(negedge clk);
        check(mem_ce1_n && !mem_ce2 && mem_oe_n && mem_we_n && mem_ub_n && mem_lb_n
              && !mem_dq_oe && !host_ack, "R1 outputs in reset",
              {mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe, host_ack},
              8'b10111100);
        rst = 1'b0;
        model_on = 1'b1;
        repeat (5) @(negedge clk);
        check(mem_ce1_n && !mem_ce2 && mem_oe_n && mem_we_n && mem_ub_n && mem_lb_n
              && !mem_dq_oe && !host_ack, "R1 outputs idle after reset",
              {mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe, host_ack},
              8'b10111100);

        // isolated accesses from idle (R2, R3, R7)
        do_op(1'b1, 19'h00010, 16'hA5C3, 2'b11, 1'b1);
        do_op(1'b0, 19'h00010, 16'h0000, 2'b11, 1'b1);

        // byte lanes (R4)
        do_op(1'b1, 19'h12345, 16'h1111, 2'b11, 1'b0);
        do_op(1'b1, 19'h12345, 16'hAB99, 2'b10, 1'b1);
        do_op(1'b1, 19'h12345, 16'h77CD, 2'b01, 1'b0);
        do_op(1'b0, 19'h12345, 16'h0000, 2'b11, 1'b0);
        do_op(1'b0, 19'h12345, 16'h0000, 2'b01, 1'b1);
        do_op(1'b0, 19'h12345, 16'h0000, 2'b10, 1'b0);

        // address extremes
        do_op(1'b1, 19'h00000, 16'h0F0F, 2'b11, 1'b0);
        do_op(1'b1, 19'h7FFFF, 16'hF00D, 2'b11, 1'b0);
        do_op(1'b0, 19'h00000, 16'h0000, 2'b11, 1'b0);
        do_op(1'b0, 19'h7FFFF, 16'h0000, 2'b11, 1'b0);

        // interleaved write/read stream (R8 ordering, R5 turnaround)
        for (int i = 0; i < 40; i++) begin
            logic [18:0] a;
            a = 19'(i * 4099 + 7);
            do_op(1'b1, a, 16'(i * 16'h3B1 + 16'h5A), 2'b11, 1'b0);
            do_op(1'b0, a, 16'h0, 2'b11, 1'b0);
        end

        // long read stream: refresh guard (R6)
        repeat (20) @(negedge clk);
        refresh_gaps = 0;
        max_run = 0;
        for (int i = 0; i < 200; i++) begin
            do_op(1'b0, 19'(i % 4 == 0 ? 19'h00010 : 19'h12345), 16'h0, 2'b11, 1'b0);
        end
        check(refresh_gaps >= 1, "R6 refresh gap inserted", refresh_gaps, 1);
        check(max_run < 1500, "R6 selection window", max_run, 1500);

        repeat (10) @(negedge clk);
        check(sq.size() == 0, "R8 every request acknowledged", sq.size(), 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule